// File: doc/BRIEF.md
# Signed Register-Mapped Divider

This block is a small arithmetic peripheral that divides signed integers on behalf of a processor. Software first loads a 32-bit divisor, then starts the operation with one write. Writing the short-dividend address divides a 32-bit signed value by the divisor. Writing the low dividend word divides a 64-bit value by the divisor. The upper half of that 64-bit value is whatever was last written to the high dividend word. The unit then works one quotient bit per clock. When it finishes, the truncated quotient and the remainder go into two address pairs, so software can read either copy.

The remainder overwrites the high dividend word, and the quotient overwrites the low dividend word. A divisor of zero clears all four result words. A quotient that does not fit in a signed 32-bit word is clamped to the largest positive or most negative value. A busy flag covers the whole computation, and a one-cycle done pulse marks the moment the results land.

Address map (word addresses): 0 divisor, 1 short dividend (start of a 32/32 divide), 2 high dividend and remainder, 3 low dividend and quotient (start of a 64/32 divide), 4 remainder copy, 5 quotient copy. Addresses 6 and 7 are unused.

Top module: `sdiv_unit`

## Requirements
- R1: After reset every register reads zero, busy and done are low and the read data output is zero.
- R2: A write to address 1 starts a signed 32/32 divide of the written value by the divisor at address 0. The quotient goes to addresses 3 and 5 and the remainder to addresses 2 and 4. The quotient truncates toward zero and the remainder has the sign of the dividend.
- R3: A write to address 3 starts a signed 64/32 divide. Its dividend is the value at address 2 as the upper word and the written value as the lower word. Results are placed as in R2.
- R4: When the divisor is zero at the start of a divide, addresses 2, 3, 4 and 5 all become zero.
- R5: A quotient above 2147483647 becomes 0x7FFFFFFF, and a quotient below -2147483648 becomes 0x80000000. The remainder still has its true value. This applies in both modes, and -2^31 / -1 in the 32-bit mode gives 0x7FFFFFFF with remainder 0.
- R6: busy rises on the clock edge that takes the starting write. done rises 33 edges later for a 32/32 divide and 65 edges later for a 64/32 divide. done stays high for exactly one cycle, and busy is low while done is high.
- R7: rdata shows, one clock after an address is presented, the register at that address. While busy is high it returns the contents from before the divide.
- R8: Writes to any address while busy is high are ignored and do not start a second divide.
- R9: Writes to addresses 0, 2, 4 and 5 only store the value and do not start a divide. Addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the word at addr |
| addr | input | 3 | Word address for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the previous cycle's addr |
| busy | output | 1 | High while a divide is in progress |
| done | output | 1 | One-cycle pulse when results are written |

## Verification
Small positive operands establish the basic quotient and remainder placement. All four sign combinations of the same magnitudes separate truncating division from floor division and check that the remainder follows the dividend's sign. Dividends that reach into the upper word set the 64-bit mode apart from the 32-bit one. Operand pairs whose quotient lands just inside, just outside and far outside the signed 32-bit range, in both signs, exercise the clamp. A zero divisor is applied after a nonzero result, so that clearing is visible. A stream of pseudo-random operands in both modes cross-checks the iteration against the language's own division and modulo operators.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam int ADDR_W   = 3;
  localparam int NUM_REGS = 6;

  localparam int IDX_DIVISOR = 0;
  localparam int IDX_DVD32   = 1;
  localparam int IDX_HI      = 2;
  localparam int IDX_LO      = 3;
  localparam int IDX_REM_M   = 4;
  localparam int IDX_QUO_M   = 5;

  typedef logic [ADDR_W-1:0] sdiv_addr_t;

  typedef enum logic {
    MODE_SHORT = 1'b0,
    MODE_LONG  = 1'b1
  } sdiv_mode_e;
endpackage

// File: rtl/sdiv_iter.sv
module sdiv_iter
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  sdiv_mode_e     mode,
  input  logic [2*W-1:0] num_mag,
  input  logic [W-1:0]   den_mag,
  output logic           valid,
  output logic [2*W-1:0] quo_mag,
  output logic [W-1:0]   rem_mag
);
  localparam int CNT_W = $clog2(2*W+1);

  logic [2*W-1:0] acc_q;
  logic [W-1:0]   rem_q;
  logic [W-1:0]   den_q;
  logic [CNT_W-1:0] cnt_q;
  logic           valid_q;

  logic [W:0]   partial;
  logic [W:0]   diff;
  logic         ge;
  logic [W-1:0] rem_nxt;

  always_comb begin
    partial = {rem_q, acc_q[2*W-1]};
    diff    = partial - {1'b0, den_q};
    ge      = (partial >= {1'b0, den_q});
    rem_nxt = ge ? diff[W-1:0] : partial[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= (cnt_q == CNT_W'(1));
      if (start) begin
        rem_q <= '0;
        den_q <= den_mag;
        if (mode == MODE_LONG) begin
          acc_q <= num_mag;
          cnt_q <= CNT_W'(2*W);
        end else begin
          acc_q <= {num_mag[W-1:0], {W{1'b0}}};
          cnt_q <= CNT_W'(W);
        end
      end else if (cnt_q != '0) begin
        rem_q <= rem_nxt;
        acc_q <= {acc_q[2*W-2:0], ge};
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign valid   = valid_q;
  assign quo_mag = acc_q;
  assign rem_mag = rem_q;

  // R6
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> (cnt_q == '0));
endmodule

// File: rtl/sdiv_fmt.sv
module sdiv_fmt #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] quo_mag,
  input  logic [W-1:0]   rem_mag,
  input  logic           neg_q,
  input  logic           neg_r,
  input  logic           zero,
  output logic [W-1:0]   quo,
  output logic [W-1:0]   rem
);
  localparam logic [2*W-1:0] POS_LIM = (2*W)'((64'd1 << (W-1)) - 64'd1);
  localparam logic [2*W-1:0] NEG_LIM = (2*W)'(64'd1 << (W-1));

  logic [2*W-1:0] q_signed;
  logic           pos_ovf;
  logic           neg_ovf;

  always_comb begin
    q_signed = neg_q ? (~quo_mag + (2*W)'(1)) : quo_mag;
    pos_ovf  = !neg_q && (quo_mag > POS_LIM);
    neg_ovf  = neg_q && (quo_mag > NEG_LIM);
    if (zero)
      quo = '0;
    else if (pos_ovf)
      quo = {1'b0, {(W-1){1'b1}}};
    else if (neg_ovf)
      quo = {1'b1, {(W-1){1'b0}}};
    else
      quo = q_signed[W-1:0];
    if (zero)
      rem = '0;
    else
      rem = neg_r ? (~rem_mag + W'(1)) : rem_mag;
  end

  // R5
  always_comb begin
    if (!zero && (pos_ovf || neg_ovf))
      sat_value_chk: assert (quo == {1'b0, {(W-1){1'b1}}} || quo == {1'b1, {(W-1){1'b0}}});
  end
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              busy,
  output logic              done
);
  logic [W-1:0] regs_q [NUM_REGS];
  logic         busy_q, done_q;
  logic         neg_q_l, neg_r_l, zero_l;
  logic [W-1:0] rdata_q;

  logic           wr_ok;
  logic           start_short, start_long, start_any;
  sdiv_mode_e     mode;
  logic [2*W-1:0] dvd;
  logic [2*W-1:0] num_mag;
  logic [W-1:0]   dsr;
  logic [W-1:0]   den_mag;
  logic           dvd_neg, dsr_neg;

  logic           core_valid;
  logic [2*W-1:0] quo_mag;
  logic [W-1:0]   rem_mag;
  logic [W-1:0]   quo_fmt, rem_fmt;
  logic [W-1:0]   rd_val;

  always_comb begin
    wr_ok       = wr_en && !busy_q;
    start_short = wr_ok && (addr == sdiv_addr_t'(IDX_DVD32));
    start_long  = wr_ok && (addr == sdiv_addr_t'(IDX_LO));
    start_any   = start_short || start_long;
    mode        = start_long ? MODE_LONG : MODE_SHORT;
    dvd         = start_long ? {regs_q[IDX_HI], wdata} : {{W{wdata[W-1]}}, wdata};
    dvd_neg     = dvd[2*W-1];
    num_mag     = dvd_neg ? (~dvd + (2*W)'(1)) : dvd;
    dsr         = regs_q[IDX_DIVISOR];
    dsr_neg     = dsr[W-1];
    den_mag     = dsr_neg ? (~dsr + W'(1)) : dsr;
  end

  sdiv_iter #(.W(W)) i_iter (
    .clk     (clk),
    .rst     (rst),
    .start   (start_any),
    .mode    (mode),
    .num_mag (num_mag),
    .den_mag (den_mag),
    .valid   (core_valid),
    .quo_mag (quo_mag),
    .rem_mag (rem_mag)
  );

  sdiv_fmt #(.W(W)) i_fmt (
    .quo_mag (quo_mag),
    .rem_mag (rem_mag),
    .neg_q   (neg_q_l),
    .neg_r   (neg_r_l),
    .zero    (zero_l),
    .quo     (quo_fmt),
    .rem     (rem_fmt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      neg_q_l <= 1'b0;
      neg_r_l <= 1'b0;
      zero_l  <= 1'b0;
    end else begin
      done_q <= core_valid;
      if (start_any) begin
        busy_q  <= 1'b1;
        neg_q_l <= dvd_neg ^ dsr_neg;
        neg_r_l <= dvd_neg;
        zero_l  <= (dsr == '0);
      end else if (core_valid) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++)
        regs_q[i] <= '0;
    end else if (core_valid) begin
      regs_q[IDX_HI]    <= rem_fmt;
      regs_q[IDX_REM_M] <= rem_fmt;
      regs_q[IDX_LO]    <= quo_fmt;
      regs_q[IDX_QUO_M] <= quo_fmt;
    end else if (wr_ok) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (addr == sdiv_addr_t'(i))
          regs_q[i] <= wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == sdiv_addr_t'(i))
        rd_val = regs_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_val;
  end

  assign rdata = rdata_q;
  assign busy  = busy_q;
  assign done  = done_q;

  // R6
  busy_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);

  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q);

  // R2
  mirror_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (regs_q[IDX_HI] == regs_q[IDX_REM_M] && regs_q[IDX_LO] == regs_q[IDX_QUO_M]));

  // R4
  zero_div_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && zero_l) |-> (regs_q[IDX_HI] == '0 && regs_q[IDX_LO] == '0 &&
                            regs_q[IDX_REM_M] == '0 && regs_q[IDX_QUO_M] == '0));

  // R8
  busy_write_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && wr_en) |=> $stable(regs_q[IDX_DIVISOR]));
endmodule

// File: tb/test_sdiv_unit.sv
`timescale 1ns/1ps
module test_sdiv_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        busy, done;

  int checks = 0;
  int failures = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  sdiv_unit i_sdiv_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy), .done(done)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] xs();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // reference: {remainder, quotient}
  function automatic logic [63:0] ref_div(longint a, int b);
    longint q, r;
    logic [31:0] qq;
    if (b == 0) return 64'd0;
    if (a == 64'sh8000_0000_0000_0000 && b == -1) return {32'd0, 32'h7FFF_FFFF};
    q = a / longint'(b);
    r = a % longint'(b);
    if (q > 64'sd2147483647) qq = 32'h7FFF_FFFF;
    else if (q < -64'sd2147483648) qq = 32'h8000_0000;
    else qq = q[31:0];
    return {r[31:0], qq};
  endfunction

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  // called at the negedge right after the starting edge
  task automatic wait_done(string tag, int exp_lat);
    int cnt = 0;
    check({tag, " R6 busy after start"}, {31'd0, busy}, 32'd1);
    while (!done && cnt < 300) begin
      @(negedge clk);
      cnt++;
    end
    check({tag, " R6 latency"}, cnt, exp_lat);
    check({tag, " R6 busy low with done"}, {31'd0, busy}, 32'd0);
    @(negedge clk);
    check({tag, " R6 done one cycle"}, {31'd0, done}, 32'd0);
  endtask

  task automatic check_results(string tag, logic [63:0] exp);
    logic [31:0] v;
    rd(3'd2, v); check({tag, " remainder"}, v, exp[63:32]);
    rd(3'd4, v); check({tag, " remainder copy"}, v, exp[63:32]);
    rd(3'd3, v); check({tag, " quotient"}, v, exp[31:0]);
    rd(3'd5, v); check({tag, " quotient copy"}, v, exp[31:0]);
  endtask

  task automatic run_short(string tag, logic [31:0] dvd, logic [31:0] dsr);
    wr(3'd0, dsr);
    wr(3'd1, dvd);
    wait_done(tag, 33);
    check_results(tag, ref_div(longint'($signed(dvd)), $signed(dsr)));
  endtask

  task automatic run_long(string tag, logic [31:0] hi, logic [31:0] lo, logic [31:0] dsr);
    wr(3'd0, dsr);
    wr(3'd2, hi);
    wr(3'd3, lo);
    wait_done(tag, 65);
    check_results(tag, ref_div($signed({hi, lo}), $signed(dsr)));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 busy at reset", {31'd0, busy}, 32'd0);
    check("R1 done at reset", {31'd0, done}, 32'd0);
    check("R1 rdata at reset", rdata, 32'd0);
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      check("R1 register reset value", v, 32'd0);
    end
  endtask

  task automatic t_short_signs();
    run_short("R2 100/7", 32'd100, 32'd7);
    run_short("R2 -100/7", -32'sd100, 32'd7);
    run_short("R2 100/-7", 32'd100, -32'sd7);
    run_short("R2 -100/-7", -32'sd100, -32'sd7);
    run_short("R2 small/large", 32'd5, 32'd9);
    run_short("R2 max/1", 32'h7FFF_FFFF, 32'd1);
    run_short("R2 min/1", 32'h8000_0000, 32'd1);
  endtask

  task automatic t_short_sat();
    run_short("R5 min/-1 short", 32'h8000_0000, 32'hFFFF_FFFF);
  endtask

  task automatic t_zero();
    run_short("R4 setup nonzero", 32'd77, 32'd5);
    run_short("R4 zero divisor short", 32'd77, 32'd0);
    run_long("R4 setup long", 32'd0, 32'd1000, 32'd3);
    run_long("R4 zero divisor long", 32'd3, 32'd1000, 32'd0);
  endtask

  task automatic t_long();
    run_long("R3 2^32/3", 32'd1, 32'd0, 32'd3);
    run_long("R3 negative dividend", 32'hFFFF_FFFF, -32'sd1000, 32'd7);
    run_long("R3 neg/neg", 32'hFFFF_FFFE, 32'h1234_5678, 32'hC000_0001);
    run_long("R3 upper word used", 32'h0000_0007, 32'h0000_0009, 32'h0000_0010);
  endtask

  task automatic t_long_sat();
    run_long("R5 pos overflow", 32'h10, 32'd0, 32'd1);
    run_long("R5 neg overflow", 32'hFFFF_FFF0, 32'd0, 32'd1);
    run_long("R5 overflow keeps remainder", 32'd1, 32'd5, 32'd2);
    run_long("R5 just fits positive", 32'd0, 32'h7FFF_FFFF, 32'd1);
    run_long("R5 just fits negative", 32'hFFFF_FFFF, 32'h8000_0000, 32'd1);
    run_long("R5 one past negative", 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'd1);
    run_long("R5 min64/-1", 32'h8000_0000, 32'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_busy_access();
    logic [31:0] v;
    run_short("R7 setup", 32'd50, 32'd4);
    wr(3'd0, 32'd3);
    wr(3'd1, 32'd100);
    // the write edge has passed; present address 3 while running
    addr = 3'd3;
    @(negedge clk);
    check("R7 read while busy returns old quotient", rdata, 32'd12);
    check("R7 busy during read", {31'd0, busy}, 32'd1);
    wr(3'd0, 32'd9);
    wr(3'd1, 32'd999);
    while (!done) @(negedge clk);
    @(negedge clk);
    check("R8 no second start", {31'd0, busy}, 32'd0);
    rd(3'd0, v); check("R8 divisor write ignored", v, 32'd3);
    rd(3'd1, v); check("R8 dividend write ignored", v, 32'd100);
    rd(3'd3, v); check("R8 result uses old operands", v, 32'd33);
    rd(3'd2, v); check("R8 remainder uses old operands", v, 32'd1);
  endtask

  task automatic t_plain();
    logic [31:0] v;
    wr(3'd2, 32'hA5A5_0001);
    check("R9 no start on address 2", {31'd0, busy}, 32'd0);
    wr(3'd4, 32'h0BAD_F00D);
    wr(3'd5, 32'h1357_9BDF);
    wr(3'd0, 32'h0000_0011);
    check("R9 no start on address 0", {31'd0, busy}, 32'd0);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd2, v); check("R9 address 2 stored", v, 32'hA5A5_0001);
    rd(3'd4, v); check("R9 address 4 stored", v, 32'h0BAD_F00D);
    rd(3'd5, v); check("R9 address 5 stored", v, 32'h1357_9BDF);
    rd(3'd0, v); check("R9 address 0 stored", v, 32'h0000_0011);
    rd(3'd6, v); check("R9 address 6 reads zero", v, 32'd0);
    rd(3'd7, v); check("R9 address 7 reads zero", v, 32'd0);
    check("R9 done never pulsed", {31'd0, done}, 32'd0);
  endtask

  task automatic t_random();
    for (int n = 0; n < 24; n++) begin
      logic [31:0] a = xs();
      logic [31:0] b = xs() >> (n % 20);
      if (n % 3 == 0) b = -b;
      run_short("R2 random short", a, b);
    end
    for (int n = 0; n < 24; n++) begin
      logic [31:0] h = xs() >> (n % 32);
      logic [31:0] l = xs();
      logic [31:0] b = xs();
      if (n % 2 == 0) h = -h;
      run_long("R3 random long", h, l, b);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_short_signs();
    t_short_sat();
    t_zero();
    t_long();
    t_long_sat();
    t_busy_access();
    t_plain();
    t_random();
    summary();
    $finish;
  end
endmodule